// File: doc/BRIEF.md
# Periodic Interval Timer with Overflow Count

The block is a memory-mapped periodic timer. A free-running prescaler divides the main clock by 16 to make a counting tick. On each tick a 20-bit current value steps up by one. When the value reaches a programmed period it returns to zero, and that return is called a wrap. Every wrap raises a period-elapsed flag and adds one to a 12-bit overflow counter. The counter tells software how many periods went by since it last acknowledged them. A level interrupt is asserted while the flag is set and interrupts are enabled. Timing keeps running when interrupts are disabled.

Software reaches four 32-bit word registers over a simple register bus. The bus takes every request in the cycle it is presented, so it has no back-pressure, and read data returns exactly one cycle later. Offset 0x0 is the mode register and offset 0x4 is the status register. The counters can be read through two views with the same layout. The view at 0x8 acknowledges, so it clears the overflow count and the flag. The view at 0xC only peeks and changes nothing. When the timer is disabled, the current value keeps counting until it wraps to zero and then stops. Software can therefore poll until the value reads zero.

Top module: `ivl_timer`

## Requirements
- R1: After reset, all four registers read zero and the interrupt output is low. Reset also clears the prescaler.
- R2: Writing offset 0x0 stores the period field from bits 19:0, the timer-enable bit from bit 24 and the interrupt-enable bit from bit 25. Reading 0x0 returns those fields in the same positions, and every other bit reads zero.
- R3: The prescaler makes a tick on every 16th main-clock cycle after reset. The first tick falls on the 16th rising edge. While the block is running, each tick adds one to the value. A tick that finds the value greater than or equal to the period field sets the value to zero instead, so the period is (field + 1) ticks.
- R4: Every wrap sets the flag, which is bit 0 of the status register at 0x4. Every wrap also adds one to the overflow count, and the count saturates at 4095.
- R5: A read of 0x8 returns the overflow count in bits 31:20 and the value in bits 19:0, both as they were in the request cycle. The read then clears the count and the flag. If a wrap falls in the same cycle as this read, the count becomes 1 and the flag stays set.
- R6: A read of 0xC returns the same layout as 0x8 and leaves the count and the flag unchanged.
- R7: While timer enable is 0, a nonzero value keeps counting until it wraps to zero, and that wrap sets the flag as usual. From then on the value holds at zero.
- R8: The interrupt output is high exactly when the flag is set and interrupt enable is 1.
- R9: Read data is valid exactly one cycle after a read request, and at no other time. Writes to 0x4, 0x8 and 0xC change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access request, accepted in its cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address; bits 3:2 select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid when bus_rvalid is high |
| bus_rvalid | output | 1 | High one cycle after a read request |
| irq | output | 1 | Level interrupt |

## Verification
An acknowledging read can fall in the same cycle as a wrap. In that cycle a clear and an increment compete for the overflow count and the flag. The bench provokes this collision by issuing acknowledging reads at a sweep of offsets from the prescaler phase. This is done with a period of one tick, so that every tick wraps, and also with longer periods. Every read word and the interrupt on every clock are judged against a behavioural model, which expects the count to read 1 and the flag to stay set after a collision.

// File: rtl/ivl_timer_pkg.sv
package ivl_timer_pkg;

  typedef enum logic [1:0] {
    REG_MODE     = 2'd0,
    REG_STATUS   = 2'd1,
    REG_VAL_ACK  = 2'd2,
    REG_VAL_PEEK = 2'd3
  } reg_idx_e;

  localparam int MODE_EN_BIT     = 24;
  localparam int MODE_IE_BIT     = 25;
  localparam int STATUS_FLAG_BIT = 0;
  localparam int WORD_LSB        = 2;

  function automatic reg_idx_e word_of(input logic [1:0] sel_bits);
    return reg_idx_e'(sel_bits);
  endfunction

endpackage

// File: rtl/ivl_prescaler.sv
module ivl_prescaler #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);

  generate
    if (DIV <= 1) begin : g_pass
      assign tick = 1'b1;
    end else begin : g_div
      localparam int PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] phase;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          phase <= '0;
        end else if (phase == LAST) begin
          phase <= '0;
        end else begin
          phase <= phase + 1'b1;
        end
      end

      assign tick = (phase == LAST);
    end
  endgenerate

endmodule

// File: rtl/ivl_count_core.sv
module ivl_count_core #(
  parameter int VAL_W = 20,
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             tmr_en,
  input  logic [VAL_W-1:0] period,
  input  logic             ack,
  output logic [VAL_W-1:0] value,
  output logic [CNT_W-1:0] ovf_cnt,
  output logic             flag,
  output logic             wrap
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic running;
  logic step;

  always_comb begin
    running = tmr_en || (value != '0);
    wrap    = tick && running && (value >= period);
    step    = tick && running && !wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value <= '0;
    end else if (wrap) begin
      value <= '0;
    end else if (step) begin
      value <= value + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_cnt <= '0;
      flag    <= 1'b0;
    end else begin
      unique case ({wrap, ack})
        2'b11: begin
          ovf_cnt <= CNT_ONE;
          flag    <= 1'b1;
        end
        2'b10: begin
          if (ovf_cnt != CNT_MAX) begin
            ovf_cnt <= ovf_cnt + 1'b1;
          end
          flag <= 1'b1;
        end
        2'b01: begin
          ovf_cnt <= '0;
          flag    <= 1'b0;
        end
        default: begin
          ovf_cnt <= ovf_cnt;
          flag    <= flag;
        end
      endcase
    end
  end

endmodule

// File: rtl/ivl_regfile.sv
module ivl_regfile
  import ivl_timer_pkg::*;
#(
  parameter int VAL_W  = 20,
  parameter int CNT_W  = 12,
  parameter int ADDR_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_sel,
  input  logic                   bus_wr,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [VAL_W+CNT_W-1:0] bus_wdata,
  input  logic [VAL_W-1:0]       value,
  input  logic [CNT_W-1:0]       ovf_cnt,
  input  logic                   flag,
  output logic [VAL_W-1:0]       period,
  output logic                   tmr_en,
  output logic                   irq_en,
  output logic                   rd_ack,
  output logic                   rd_peek,
  output logic                   rd_req,
  output logic                   mode_wr,
  output logic [VAL_W+CNT_W-1:0] bus_rdata,
  output logic                   bus_rvalid
);

  localparam int DW = VAL_W + CNT_W;

  reg_idx_e       idx;
  logic [DW-1:0]  rd_word;
  logic           unused_bits;

  assign idx     = word_of(bus_addr[WORD_LSB+1:WORD_LSB]);
  assign rd_req  = bus_sel && !bus_wr;
  assign mode_wr = bus_sel && bus_wr && (idx == REG_MODE);
  assign rd_ack  = rd_req && (idx == REG_VAL_ACK);
  assign rd_peek = rd_req && (idx == REG_VAL_PEEK);

  assign unused_bits = ^{bus_addr[WORD_LSB-1:0], bus_wdata[MODE_EN_BIT-1:VAL_W],
                         bus_wdata[DW-1:MODE_IE_BIT+1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period <= '0;
      tmr_en <= 1'b0;
      irq_en <= 1'b0;
    end else if (mode_wr) begin
      period <= bus_wdata[VAL_W-1:0];
      tmr_en <= bus_wdata[MODE_EN_BIT];
      irq_en <= bus_wdata[MODE_IE_BIT];
    end
  end

  always_comb begin
    rd_word = '0;
    unique case (idx)
      REG_MODE: begin
        rd_word[VAL_W-1:0]  = period;
        rd_word[MODE_EN_BIT] = tmr_en;
        rd_word[MODE_IE_BIT] = irq_en;
      end
      REG_STATUS: begin
        rd_word[STATUS_FLAG_BIT] = flag;
      end
      default: begin
        rd_word = {ovf_cnt, value};
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= rd_req;
      if (rd_req) begin
        bus_rdata <= rd_word;
      end
    end
  end

endmodule

// File: rtl/ivl_timer.sv
module ivl_timer #(
  parameter int PRESCALE = 16,
  parameter int VAL_W    = 20,
  parameter int CNT_W    = 12,
  parameter int ADDR_W   = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_sel,
  input  logic                   bus_wr,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [VAL_W+CNT_W-1:0] bus_wdata,
  output logic [VAL_W+CNT_W-1:0] bus_rdata,
  output logic                   bus_rvalid,
  output logic                   irq
);

  logic             tick;
  logic [VAL_W-1:0] period;
  logic             tmr_en;
  logic             irq_en;
  logic             rd_ack;
  logic             rd_peek;
  logic             rd_req;
  logic             mode_wr;
  logic [VAL_W-1:0] value;
  logic [CNT_W-1:0] ovf_cnt;
  logic             flag;
  logic             wrap;

  ivl_prescaler #(.DIV(PRESCALE)) u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick)
  );

  ivl_count_core #(.VAL_W(VAL_W), .CNT_W(CNT_W)) u_core (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .tmr_en (tmr_en),
    .period (period),
    .ack    (rd_ack),
    .value  (value),
    .ovf_cnt(ovf_cnt),
    .flag   (flag),
    .wrap   (wrap)
  );

  ivl_regfile #(.VAL_W(VAL_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .value     (value),
    .ovf_cnt   (ovf_cnt),
    .flag      (flag),
    .period    (period),
    .tmr_en    (tmr_en),
    .irq_en    (irq_en),
    .rd_ack    (rd_ack),
    .rd_peek   (rd_peek),
    .rd_req    (rd_req),
    .mode_wr   (mode_wr),
    .bus_rdata (bus_rdata),
    .bus_rvalid(bus_rvalid)
  );

  assign irq = flag && irq_en;

endmodule

// File: rtl/ivl_timer_chk.sv
module ivl_timer_chk #(
  parameter int VAL_W = 20,
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic [VAL_W-1:0] value,
  input logic [CNT_W-1:0] ovf_cnt,
  input logic             flag,
  input logic             tmr_en,
  input logic             irq_en,
  input logic             irq,
  input logic             rd_ack,
  input logic             rd_peek,
  input logic             rd_req,
  input logic             wrap,
  input logic             bus_rvalid
);

  localparam logic [CNT_W-1:0] CMAX = '1;
  localparam logic [CNT_W-1:0] CONE = CNT_W'(1);

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(value)); // R3

  AST_WRAP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (flag && ovf_cnt != '0)); // R4

  AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_cnt == CMAX && !rd_ack) |=> ovf_cnt == CMAX); // R4

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ack && !wrap) |=> (!flag && ovf_cnt == '0)); // R5

  AST_ACK_COLLIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ack && wrap) |=> (flag && ovf_cnt == CONE)); // R5

  AST_PEEK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_peek && !wrap) |=> ($stable(ovf_cnt) && $stable(flag))); // R6

  AST_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmr_en && value == '0) |=> value == '0); // R7

  AST_IRQ_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag); // R8

  AST_IRQ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq); // R8

  AST_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> bus_rvalid); // R9

  AST_NO_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !bus_rvalid); // R9

endmodule

bind ivl_timer ivl_timer_chk #(.VAL_W(VAL_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick),
  .value     (value),
  .ovf_cnt   (ovf_cnt),
  .flag      (flag),
  .tmr_en    (tmr_en),
  .irq_en    (irq_en),
  .irq       (irq),
  .rd_ack    (rd_ack),
  .rd_peek   (rd_peek),
  .rd_req    (rd_req),
  .wrap      (wrap),
  .bus_rvalid(bus_rvalid)
);

// File: tb/ivl_timer_test.sv
`timescale 1ns/1ps
module ivl_timer_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0;
  logic        wr = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid;
  logic        irq;
  string       cur_tag = "R1";

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ivl_timer uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .bus_rvalid(rvalid), .irq(irq)
  );

  // behavioural reference model
  int          m_pre, m_val, m_cnt, m_per;
  bit          m_flag, m_en, m_ie;
  bit          exp_rvalid, exp_irq;
  logic [31:0] exp_rdata;
  string       exp_tag;

  always @(posedge clk) begin
    bit tk, ack, wrp, run;
    if (!rst_n) begin
      m_pre = 0; m_val = 0; m_cnt = 0; m_per = 0;
      m_flag = 0; m_en = 0; m_ie = 0;
      exp_rvalid = 0; exp_irq = 0; exp_rdata = '0; exp_tag = "R1";
    end else begin
      tk = (m_pre == 15);
      m_pre = (m_pre + 1) % 16;
      exp_rvalid = sel && !wr;
      if (exp_rvalid) begin
        exp_tag = cur_tag;
        case (addr[3:2])
          2'd0: exp_rdata = 32'(m_per) | (32'(m_en) << 24) | (32'(m_ie) << 25);
          2'd1: exp_rdata = 32'(m_flag);
          default: exp_rdata = (32'(m_cnt) << 20) | 32'(m_val);
        endcase
      end
      ack = sel && !wr && (addr[3:2] == 2'd2);
      run = m_en || (m_val != 0);
      wrp = tk && run && (m_val >= m_per);
      if (wrp) m_val = 0;
      else if (tk && run) m_val = m_val + 1;
      if (wrp && ack) begin m_cnt = 1; m_flag = 1; end
      else if (wrp) begin if (m_cnt < 4095) m_cnt = m_cnt + 1; m_flag = 1; end
      else if (ack) begin m_cnt = 0; m_flag = 0; end
      if (sel && wr && addr[3:2] == 2'd0) begin
        m_per = int'(wdata[19:0]); m_en = wdata[24]; m_ie = wdata[25];
      end
      exp_irq = m_flag && m_ie;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check(rvalid == exp_rvalid, "R9 read valid timing", 32'(rvalid), 32'(exp_rvalid));
      if (exp_rvalid && rvalid)
        check(rdata == exp_rdata, {exp_tag, " read data"}, rdata, exp_rdata);
      check(irq == exp_irq, "R8 interrupt level", 32'(irq), 32'(exp_irq));
    end
  end

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk);
    sel = 0; wr = 0;
  endtask

  task automatic bus_read(input logic [3:0] a, input string t);
    @(negedge clk);
    sel = 1; wr = 0; addr = a; cur_tag = t;
    @(negedge clk);
    sel = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    idle(3);
    check(irq == 1'b0 && rvalid == 1'b0, "R1 outputs in reset", {30'b0, irq, rvalid}, 32'h0);
    rst_n = 1;
    // R1: every register reads zero after reset
    bus_read(4'h0, "R1");
    bus_read(4'h4, "R1");
    bus_read(4'h8, "R1");
    bus_read(4'hC, "R1");

    // R2: mode fields, junk bits must read back zero
    bus_write(4'h0, 32'hFCF0_0003 | 32'h0300_0000);
    bus_read(4'h0, "R2");

    // R3/R4: periodic counting with peeks and status reads
    for (int i = 0; i < 30; i++) begin
      idle(7 + i);
      bus_read(4'hC, "R3");
      bus_read(4'h4, "R4");
    end
    bus_read(4'hC, "R6");
    bus_read(4'hC, "R6");

    // R5: acknowledging reads swept across the tick phase, period of one tick
    bus_write(4'h0, 32'h0300_0000);
    for (int k = 0; k < 48; k++) begin
      idle(k % 19);
      bus_read(4'h8, "R5");
      bus_read(4'h4, "R5");
    end
    // longer period, same sweep
    bus_write(4'h0, 32'h0300_0002);
    for (int k = 0; k < 40; k++) begin
      idle(k % 23 + 3);
      bus_read(4'h8, "R5");
    end

    // R8: interrupt masked while timing continues
    bus_write(4'h0, 32'h0100_0003);
    idle(200);
    bus_read(4'hC, "R8");
    bus_write(4'h0, 32'h0300_0003);
    idle(100);
    bus_read(4'h8, "R8");

    // R7: disable mid-period, value runs to zero then stops
    bus_write(4'h0, 32'h0100_0007);
    idle(50);
    bus_write(4'h0, 32'h0000_0007);
    for (int i = 0; i < 12; i++) begin
      idle(13);
      bus_read(4'hC, "R7");
    end
    idle(200);
    bus_read(4'hC, "R7");
    bus_write(4'h0, 32'h0000_0000);
    idle(40);
    bus_read(4'hC, "R7");

    // R9: writes to read-only words change nothing
    bus_write(4'h0, 32'h0100_0005);
    idle(60);
    bus_write(4'h4, 32'hFFFF_FFFF);
    bus_write(4'h8, 32'hFFFF_FFFF);
    bus_write(4'hC, 32'hFFFF_FFFF);
    bus_read(4'hC, "R9");
    bus_read(4'h4, "R9");
    bus_read(4'h0, "R9");

    // R4: overflow count saturation
    bus_read(4'h8, "R5");
    bus_write(4'h0, 32'h0100_0000);
    idle(4100 * 16);
    bus_read(4'hC, "R4");
    idle(64);
    bus_read(4'hC, "R4");
    bus_read(4'h8, "R5");
    idle(40);
    bus_read(4'hC, "R6");

    idle(4);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule